// File: doc/BRIEF.md
# Memory-Mapped Lite UART Register Block

This block connects a processor bus to an external byte stream. A bus master sees four 32-bit registers spaced one word apart. From the lowest offset upward they are: the oldest received byte, the last transmitted word, a status word and a control word. Received bytes arrive through a valid/ready handshake and wait in a small circular queue. A write to the transmit register sends its low byte out on a one-cycle strobe, in the same cycle as the write. Serial timing, baud generation, parity and framing are not part of this block, and the error bits of the status word always read zero.

One level interrupt output is provided. It is the AND of two bits. The first is a sticky pending flag, which is set by received data or by any transmit write. The second is an enable bit in the control word.

Back-pressure works as follows. The receive port accepts a byte on a clock edge only when `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the queue holds its full depth, and it is also low during a bus write to control that clears the queue. A source that holds `rx_valid` high keeps its byte until `rx_ready` returns. The transmit strobe has no ready signal: the downstream side must take every byte.

Bus accesses take one cycle. `bus_req` qualifies an access and `bus_we` selects a write. Read data is combinational during the request cycle, and all state changes on the closing clock edge.

Top module: `lite_uart_regs`

## Requirements
- R1: Registers are selected by byte-address bits 3:2: 0 selects receive data, 1 selects transmit data, 2 selects status and 3 selects control. Reading control returns the last value written there. Reading transmit returns the last value written there. Both read 0 after reset.
- R2: The receive queue holds up to 8 bytes. Reading receive data returns the oldest held byte in bits 7:0, with the upper bits zero, and removes that byte from the queue.
- R3: `rx_ready` is high exactly when fewer than 8 bytes are held and no queue-clearing control write is in progress. A byte is stored only on an edge where `rx_valid` and `rx_ready` are both high.
- R4: Reading receive data while the queue is empty returns the slot at the current write position. That slot holds zero after reset, or a byte left behind by earlier traffic. The held count stays at zero.
- R5: The status word has these fields. Bit 0 is high when at least one byte is held. Bit 1 is high when 8 bytes are held. Bit 2 always reads 1. Bit 3 always reads 0. Bit 4 is the pending flag. Bits 7:5 and all bits above 7 read 0.
- R6: A control write with bit 1 set empties the queue and returns the write position to slot 0. A byte offered in that cycle is refused. The written value is stored either way, and bit 0 has no effect beyond being stored.
- R7: A bus write to the transmit register raises `tx_valid` in that cycle, with `tx_data` equal to the written bits 7:0. The write also sets the pending flag.
- R8: The pending flag is set whenever the queue is non-empty after a cycle. A status read clears the flag, unless bytes are held after that access.
- R9: `irq` equals the pending flag AND control bit 4.
- R10: Bus writes to the status and receive-data addresses change no state.
- R11: When a receive-data read and an accepted byte fall in the same cycle, the count is unchanged and the byte order is preserved.
- R12: After reset the queue is empty, status reads 0x04, `rx_ready` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data during a read request, otherwise 0 |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | BYTE_W | Incoming byte |
| rx_ready | output | 1 | Block can take a byte this cycle |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | BYTE_W | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle. The first case is a bus pop of the queue together with an incoming byte. The bench provokes it by reading receive data while `rx_valid` is held high, both from a full queue (where ready opens only after the pop) and from an empty queue (where the read returns the old slot while the new byte lands). The second case is a queue-clearing control write together with an offered byte; there the bench expects `rx_ready` low and an empty queue afterwards. A behavioural queue model decides each expected read value, ready level and interrupt level on every cycle, and a random phase then mixes all the accesses.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  typedef enum logic [1:0] {
    RG_RXD  = 2'd0,
    RG_TXD  = 2'd1,
    RG_STAT = 2'd2,
    RG_CTRL = 2'd3
  } reg_sel_e;

  localparam int SEL_LO = 2;
  localparam int SEL_HI = 3;

  localparam int ST_RXV  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_TXF  = 3;
  localparam int ST_PEND = 4;

  localparam int CT_TXRST = 0;
  localparam int CT_RXCLR = 1;
  localparam int CT_IEN   = 4;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop,
  input  logic              clr,
  output logic [BYTE_W-1:0] dout,
  output logic [CNT_W-1:0]  cnt,
  output logic              full,
  output logic              nonempty_nxt
);
  localparam int IW = CNT_W + 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, wp_nxt, rd_idx;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [IW-1:0]     rd_sum;
  logic              pop_ok;

  // oldest slot = write position minus count, wrapped into the ring
  assign rd_sum = IW'(wp) + IW'(DEPTH) - IW'(cnt);
  assign rd_idx = (rd_sum >= IW'(DEPTH)) ? PTR_W'(rd_sum - IW'(DEPTH)) : PTR_W'(rd_sum);
  assign dout   = mem[rd_idx];
  assign full   = (cnt == CNT_W'(DEPTH));
  assign pop_ok = pop && (cnt != '0);

  always_comb begin
    cnt_nxt = cnt;
    wp_nxt  = wp;
    if (clr) begin
      cnt_nxt = '0;
      wp_nxt  = '0;
    end else begin
      if (push) wp_nxt = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
      if (push && !pop_ok)      cnt_nxt = cnt + CNT_W'(1);
      else if (!push && pop_ok) cnt_nxt = cnt - CNT_W'(1);
    end
  end

  assign nonempty_nxt = (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wp  <= wp_nxt;
      cnt <= cnt_nxt;
      if (push && !clr) mem[wp] <= din;
    end
  end
endmodule

// File: rtl/uart_stat_ctl.sv
module uart_stat_ctl
  import lite_uart_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              tx_we,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_nonempty_nxt,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] tx_q,
  output logic              pend,
  output logic              irq
);
  logic pend_nxt;

  assign pend_nxt = tx_we || rx_nonempty_nxt || (pend && !stat_rd);
  assign irq      = pend && ctrl_q[CT_IEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tx_q   <= '0;
      pend   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      if (tx_we)   tx_q   <= wdata;
      pend <= pend_nxt;
    end
  end
endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int RXQ_DEPTH = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  localparam int CNT_W = $clog2(RXQ_DEPTH + 1);

  reg_sel_e          sel;
  logic              rd_rx, wr_tx, rd_st, wr_st, wr_rx, wr_ct, rx_clr, push;
  logic [BYTE_W-1:0] q_dout;
  logic [CNT_W-1:0]  q_cnt;
  logic              q_full, q_nonempty_nxt;
  logic [DATA_W-1:0] ctrl_q, tx_q, stat_w, rd_mux;
  logic              pend;

  assign sel    = reg_sel_e'(bus_addr[SEL_HI:SEL_LO]);
  assign rd_rx  = bus_req && !bus_we && (sel == RG_RXD);
  assign rd_st  = bus_req && !bus_we && (sel == RG_STAT);
  assign wr_rx  = bus_req &&  bus_we && (sel == RG_RXD);
  assign wr_tx  = bus_req &&  bus_we && (sel == RG_TXD);
  assign wr_st  = bus_req &&  bus_we && (sel == RG_STAT);
  assign wr_ct  = bus_req &&  bus_we && (sel == RG_CTRL);
  assign rx_clr = wr_ct && bus_wdata[CT_RXCLR];

  assign rx_ready = !q_full && !rx_clr;
  assign push     = rx_valid && rx_ready;

  assign tx_valid = wr_tx;
  assign tx_data  = bus_wdata[BYTE_W-1:0];

  rxq_ring #(.DEPTH(RXQ_DEPTH), .BYTE_W(BYTE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din(rx_data),
    .pop(rd_rx), .clr(rx_clr),
    .dout(q_dout), .cnt(q_cnt), .full(q_full),
    .nonempty_nxt(q_nonempty_nxt)
  );

  uart_stat_ctl #(.DATA_W(DATA_W)) u_sc (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(wr_ct), .tx_we(wr_tx), .stat_rd(rd_st),
    .wdata(bus_wdata), .rx_nonempty_nxt(q_nonempty_nxt),
    .ctrl_q(ctrl_q), .tx_q(tx_q), .pend(pend), .irq(irq)
  );

  always_comb begin
    stat_w          = '0;
    stat_w[ST_RXV]  = (q_cnt != '0);
    stat_w[ST_RXF]  = q_full;
    stat_w[ST_TXE]  = 1'b1;
    stat_w[ST_TXF]  = 1'b0;
    stat_w[ST_PEND] = pend;
  end

  always_comb begin
    case (sel)
      RG_RXD:  rd_mux = DATA_W'(q_dout);
      RG_TXD:  rd_mux = tx_q;
      RG_STAT: rd_mux = stat_w;
      default: rd_mux = ctrl_q;
    endcase
  end

  assign bus_rdata = (bus_req && !bus_we) ? rd_mux : '0;
endmodule

// File: rtl/lite_uart_chk.sv
module lite_uart_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_clr,
  input logic              wr_st,
  input logic              wr_rx,
  input logic              tx_valid,
  input logic              rx_ready,
  input logic              irq,
  input logic              pend,
  input logic              ien,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R2

  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(DEPTH)) |-> !rx_ready); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (cnt == '0)); // R6

  AST_TX_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> pend); // R7

  AST_DATA_HOLDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> pend); // R8

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && ien)); // R9

  AST_STAT_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st || wr_rx) |=> $stable(ctrl_q)); // R10
endmodule

bind lite_uart_regs lite_uart_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DEPTH(RXQ_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_clr(rx_clr), .wr_st(wr_st), .wr_rx(wr_rx),
  .tx_valid(tx_valid), .rx_ready(rx_ready), .irq(irq), .pend(pend),
  .ien(ctrl_q[4]), .ctrl_q(ctrl_q), .cnt(q_cnt)
);

// File: tb/sim_lite_uart_regs.sv
`timescale 1ns/1ps
module sim_lite_uart_regs;
  localparam int DW  = 32;
  localparam int BW  = 8;
  localparam int DEP = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, rx_valid = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [BW-1:0] rx_data = '0;
  logic [DW-1:0] bus_rdata;
  logic          rx_ready, tx_valid, irq;
  logic [BW-1:0] tx_data;

  lite_uart_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] last_rd;

  // behavioural model state
  int          m_mem[DEP];
  int          m_wp, m_cnt;
  bit          m_pend;
  logic [DW-1:0] m_ctrl, m_tx;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit req, bit we, logic [3:0] a, logic [DW-1:0] wd,
                      bit rv, logic [BW-1:0] rd, string tag);
    bit exp_rdy, pop;
    int sel, ridx;
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_data = rd;
    #1;
    sel = int'(a[3:2]);
    exp_rdy = (m_cnt < DEP) && !(req && we && sel == 3 && wd[1]);
    chk("R3 rx_ready", {31'b0, rx_ready}, {31'b0, exp_rdy});
    chk("R7 tx_valid", {31'b0, tx_valid}, {31'b0, (req && we && sel == 1)});
    if (req && we && sel == 1) chk("R7 tx_data", {24'b0, tx_data}, {24'b0, wd[7:0]});
    chk("R9 irq", {31'b0, irq}, {31'b0, (m_pend && m_ctrl[4])});
    if (req && !we) begin
      ridx = (m_wp - m_cnt + DEP) % DEP;
      case (sel)
        0:       exp_rd = 32'(m_mem[ridx]);
        1:       exp_rd = m_tx;
        2:       exp_rd = {27'b0, m_pend, 1'b0, 1'b1, (m_cnt == DEP), (m_cnt != 0)};
        default: exp_rd = m_ctrl;
      endcase
      last_rd = bus_rdata;
      chk(tag, bus_rdata, exp_rd);
    end
    @(posedge clk);
    pop = req && !we && sel == 0 && m_cnt > 0;
    if (rv && exp_rdy) begin
      m_mem[m_wp] = int'(rd);
      m_wp = (m_wp + 1) % DEP;
      m_cnt++;
    end
    if (pop) m_cnt--;
    if (req && we && sel == 3) begin
      m_ctrl = wd;
      if (wd[1]) begin m_wp = 0; m_cnt = 0; end
    end
    if (req && we && sel == 1) begin m_tx = wd; m_pend = 1'b1; end
    if (req && !we && sel == 2) m_pend = 1'b0;
    if (m_cnt != 0) m_pend = 1'b1;
  endtask

  task automatic idle();
    step(0, 0, 4'h0, '0, 0, '0, "idle");
  endtask
  task automatic rd(logic [3:0] a, string tag);
    step(1, 0, a, '0, 0, '0, tag);
  endtask
  task automatic wr(logic [3:0] a, logic [DW-1:0] d, string tag);
    step(1, 1, a, d, 0, '0, tag);
  endtask
  task automatic feed(logic [BW-1:0] b);
    step(0, 0, 4'h0, '0, 1, b, "R3 feed");
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    for (int i = 0; i < DEP; i++) m_mem[i] = 0;
    m_wp = 0; m_cnt = 0; m_pend = 1'b0; m_ctrl = '0; m_tx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R12 reset state
    rd(4'h8, "R12 status after reset");
    chk("R12 status literal", last_rd, 32'h0000_0004);
    rd(4'hC, "R1 ctrl reset value");
    rd(4'h4, "R1 tx reset value");

    // R4 empty read returns zeroed slot, count stays 0
    rd(4'h0, "R4 empty read");
    chk("R4 empty literal", last_rd, 32'h0);
    rd(4'h8, "R4 status still empty");

    // R7 transmit sets pending, R8 status read clears it
    wr(4'h4, 32'h0000_01A5, "R7 tx write");
    rd(4'h4, "R1 tx readback");
    rd(4'h8, "R8 pending seen");
    chk("R8 pending literal", last_rd, 32'h0000_0014);
    rd(4'h8, "R8 pending cleared");
    chk("R8 cleared literal", last_rd, 32'h0000_0004);

    // R9 interrupt gating
    wr(4'hC, 32'h0000_0010, "R9 enable");
    rd(4'hC, "R1 ctrl readback");
    wr(4'h4, 32'h0000_0033, "R9 tx raises irq");
    idle();
    rd(4'h8, "R9 status read drops irq");
    idle();

    // R2 / R3 / R5 fill past capacity
    for (int i = 0; i < DEP; i++) feed(8'h40 + 8'(i));
    feed(8'hEE);
    feed(8'hEF);
    rd(4'h8, "R5 full status");
    chk("R5 full literal", last_rd, 32'h0000_0017);
    rd(4'h8, "R8 status read keeps pending with data");

    // R11 pop while a byte is offered
    for (int i = 0; i < 4; i++) step(1, 0, 4'h0, '0, 1, 8'h80 + 8'(i), "R11 pop with push");
    for (int i = 0; i < DEP; i++) rd(4'h0, "R2 drain order");
    rd(4'h0, "R4 read after drain");
    step(1, 0, 4'h0, '0, 1, 8'h5A, "R11 empty pop with push");
    rd(4'h0, "R2 single byte");

    // R10 writes to status and receive addresses ignored
    feed(8'h11);
    rd(4'hC, "R10 ctrl before");
    wr(4'h8, 32'hFFFF_FFFF, "R10 status write");
    wr(4'h0, 32'h0000_00FF, "R10 rx write");
    rd(4'h8, "R10 status unchanged");
    rd(4'hC, "R10 ctrl unchanged");
    rd(4'h0, "R10 rx data unchanged");

    // R6 queue clear with a byte offered the same cycle
    feed(8'h21); feed(8'h22); feed(8'h23);
    step(1, 1, 4'hC, 32'h0000_0013, 1, 8'h99, "R6 clear");
    rd(4'hC, "R6 ctrl stored");
    rd(4'h8, "R6 status after clear");
    feed(8'h31);
    rd(4'h0, "R6 slot zero after clear");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 3)      step(1, 0, 4'h0, '0, ($urandom % 2) == 1, 8'($urandom), "R2 rand rx read");
      else if (r < 4) step(1, 0, 4'h8, '0, ($urandom % 2) == 1, 8'($urandom), "R5 rand status");
      else if (r < 5) step(1, 1, 4'h4, 32'($urandom), ($urandom % 2) == 1, 8'($urandom), "R7 rand tx");
      else if (r < 6) step(1, 1, 4'hC, 32'($urandom) & 32'h13, ($urandom % 2) == 1, 8'($urandom), "R6 rand ctrl");
      else if (r < 7) step(1, 0, 4'hC, '0, 1, 8'($urandom), "R1 rand ctrl read");
      else            step(0, 0, 4'h0, '0, 1, 8'($urandom), "R3 rand feed");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule